// File: doc/BRIEF.md
# Peripheral Low-Power Stop Controller

This block puts a bus peripheral's core into a low-power stop state and brings it back out. It decides when the core clock may be switched off. It exposes one 8-bit control register on a simple register port. Through that register software can:

- request stop;
- arm a wake-up on bus activity;
- select an automatic power-save mode;
- make the register reachable only in supervisor privilege.

A read-only acknowledge bit in the register tells software when the clock is really off.

A stop request takes effect only after the core reports that it is idle. The clock enable falls first, and the acknowledge follows one cycle later. The stop ends in one of two ways. Software can clear the stop bit. Or, with wake-up armed, the block detects a recessive-to-dominant (1 to 0) transition on the receive line and clears the stop bit itself. The receive line is resynchronised on the free-running clock.

Arming wake-up in the same cycle as a detected bus edge is refused. Software reads the bit back to confirm it. In power-save mode the clock is switched off whenever the core has no pending task, and it comes back when a task appears.

Top module: `lpstop_ctrl`

## Requirements
- R1: After reset all control bits are 0, the readback is 0x00, core_clk_en is 1 and stop_ack is 0.
- R2: Register layout: bit 7 supervisor lock, bit 6 wake arm, bit 5 power-save, bit 4 acknowledge (read-only), bit 3 stop request. Bits 2..0 always read 0, and writes to them are ignored.
- R3: While the stop bit is set and core_idle is 0, core_clk_en stays 1 and stop_ack stays 0.
- R4: With the stop bit set and core_idle 1, core_clk_en falls on the next edge. stop_ack rises one edge after that. stop_ack is never 1 while core_clk_en is 1.
- R5: When software clears the stop bit while stop_ack is 1, core_clk_en returns to 1 and stop_ack to 0 together, one edge after the write.
- R6: With wake armed and the clock stopped, a 1-to-0 transition on rx_pin clears the stop bit without software action. The clock restarts SYNC_STAGES+2 edges after the first edge that samples the low level. The wake arm bit stays 1.
- R7: With wake not armed, transitions on rx_pin leave a stopped block stopped.
- R8: A write that would arm wake, landing in the cycle where a bus edge is detected, leaves the wake bit 0. The same write does not change the stop bit, so the clock is not stopped.
- R9: With power-save set and no stop request, core_clk_en is 0 one edge after task_pending is 0. It is 1 one edge after task_pending is 1, or one edge after power-save is cleared. stop_ack stays 0 throughout.
- R10: With the lock bit set, a write with priv_super 0 leaves the register unchanged and raises acc_err for exactly the following cycle. A read with priv_super 0 returns 0x00.
- R11: With the lock bit clear, reads and writes with priv_super 0 act as supervisor accesses, and acc_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| priv_super | input | 1 | 1 = supervisor access, 0 = user access |
| reg_rdata | output | 8 | Read data (combinational, 0 when no read is active or the read is refused) |
| acc_err | output | 1 | One-cycle pulse after a refused write |
| rx_pin | input | 1 | Bus receive line, asynchronous |
| core_idle | input | 1 | Core has finished its current activity |
| task_pending | input | 1 | Core has work waiting (power-save mode) |
| core_clk_en | output | 1 | Enable for the core clock gate, registered |
| stop_ack | output | 1 | Clock is stopped by a stop request |

## Verification
The register port is swept through every write value with the stop bit clear. This separates the stored bits from the forced-zero and read-only bits.

Stop entry is tried twice: once with the core busy and then going idle, and once idle from the start. This separates the waiting behaviour from the gate/acknowledge ordering.

Bus edges are applied in three situations:
- while armed and stopped, which must wake the block;
- while unarmed and stopped, which must be ignored;
- exactly in the cycle of an arming write, which must be refused.

Power-save is toggled against task_pending. Supervisor and user accesses are tried with the lock bit both set and clear.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;
   localparam int unsigned CTL_W    = 8;
   localparam int unsigned BIT_LOCK = 7;
   localparam int unsigned BIT_WAKE = 6;
   localparam int unsigned BIT_AUTO = 5;
   localparam int unsigned BIT_ACK  = 4;
   localparam int unsigned BIT_STOP = 3;

   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_DRAIN   = 3'd1,
      ST_GATED   = 3'd2,
      ST_STOPPED = 3'd3,
      ST_NAP     = 3'd4
   } pwr_state_e;

   typedef struct packed {
      logic lock;
      logic wake;
      logic autos;
      logic stop;
   } ctl_t;
endpackage

// File: rtl/lpstop_rxedge.sv
module lpstop_rxedge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_in,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lpstop_rxedge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= rx_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/lpstop_regs.sv
module lpstop_regs
   import lpstop_pkg::*;
#(
   parameter bit WAKE_PRESENT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             rd,
   input  logic [CTL_W-1:0] wdata,
   input  logic             priv_super,
   input  logic             rx_fall,
   input  logic             in_stop,
   input  logic             ack,
   output ctl_t             ctl,
   output logic [CTL_W-1:0] rdata,
   output logic             acc_err
);
   logic lock_q, wake_q, auto_q, stop_q;
   logic allowed, wr_ok, arm_block, wake_evt;
   logic [CTL_W-1:0] image;

   assign allowed   = ~lock_q | priv_super;
   assign wr_ok     = wr & allowed;
   assign arm_block = wr_ok & wdata[BIT_WAKE] & ~wake_q & rx_fall;
   assign wake_evt  = wake_q & rx_fall & in_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q  <= 1'b0;
         auto_q  <= 1'b0;
         stop_q  <= 1'b0;
         acc_err <= 1'b0;
      end else begin
         acc_err <= wr & ~allowed;
         if (wr_ok) begin
            lock_q <= wdata[BIT_LOCK];
            auto_q <= wdata[BIT_AUTO];
            if (!arm_block) stop_q <= wdata[BIT_STOP];
         end
         if (wake_evt) stop_q <= 1'b0;
      end
   end

   generate
      if (WAKE_PRESENT) begin : g_wake
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  wake_q <= 1'b0;
            else if (wr_ok && !arm_block) wake_q <= wdata[BIT_WAKE];
         end
      end else begin : g_no_wake
         assign wake_q = 1'b0;
      end
   endgenerate

   always_comb begin
      image           = '0;
      image[BIT_LOCK] = lock_q;
      image[BIT_WAKE] = wake_q;
      image[BIT_AUTO] = auto_q;
      image[BIT_ACK]  = ack;
      image[BIT_STOP] = stop_q;
   end

   assign rdata = (rd && allowed) ? image : '0;
   assign ctl   = '{lock: lock_q, wake: wake_q, autos: auto_q, stop: stop_q};
endmodule

// File: rtl/lpstop_fsm.sv
module lpstop_fsm
   import lpstop_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic stop_req,
   input  logic auto_save,
   input  logic core_idle,
   input  logic task_pending,
   output logic clk_en,
   output logic ack,
   output logic in_stop
);
   pwr_state_e state, nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_RUN: begin
            if (stop_req)                      nxt = core_idle ? ST_GATED : ST_DRAIN;
            else if (auto_save && !task_pending) nxt = ST_NAP;
         end
         ST_DRAIN: begin
            if (!stop_req)      nxt = ST_RUN;
            else if (core_idle) nxt = ST_GATED;
         end
         ST_GATED:   nxt = stop_req ? ST_STOPPED : ST_RUN;
         ST_STOPPED: if (!stop_req) nxt = ST_RUN;
         ST_NAP:     if (stop_req || !auto_save || task_pending) nxt = ST_RUN;
         default:    nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_RUN;
         clk_en <= 1'b1;
         ack    <= 1'b0;
      end else begin
         state  <= nxt;
         clk_en <= !(nxt inside {ST_GATED, ST_STOPPED, ST_NAP});
         ack    <= (nxt == ST_STOPPED);
      end
   end

   assign in_stop = (state == ST_GATED) || (state == ST_STOPPED);
endmodule

// File: rtl/lpstop_ctrl.sv
module lpstop_ctrl
   import lpstop_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          WAKE_PRESENT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [7:0] reg_wdata,
   input  logic       priv_super,
   output logic [7:0] reg_rdata,
   output logic       acc_err,
   input  logic       rx_pin,
   input  logic       core_idle,
   input  logic       task_pending,
   output logic       core_clk_en,
   output logic       stop_ack
);
   generate
      if (CTL_W != 8) begin : g_bad_width
         $error("lpstop_ctrl: control register must be 8 bits");
      end
   endgenerate

   ctl_t ctl;
   logic rx_fall;
   logic in_stop;

   lpstop_rxedge #(.STAGES(SYNC_STAGES)) u_rxedge (
      .clk   (clk),
      .rst_n (rst_n),
      .rx_in (rx_pin),
      .fall  (rx_fall)
   );

   lpstop_regs #(.WAKE_PRESENT(WAKE_PRESENT)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reg_wr),
      .rd         (reg_rd),
      .wdata      (reg_wdata),
      .priv_super (priv_super),
      .rx_fall    (rx_fall),
      .in_stop    (in_stop),
      .ack        (stop_ack),
      .ctl        (ctl),
      .rdata      (reg_rdata),
      .acc_err    (acc_err)
   );

   lpstop_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .stop_req     (ctl.stop),
      .auto_save    (ctl.autos),
      .core_idle    (core_idle),
      .task_pending (task_pending),
      .clk_en       (core_clk_en),
      .ack          (stop_ack),
      .in_stop      (in_stop)
   );
endmodule

// File: rtl/lpstop_chk.sv
module lpstop_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic       reg_rd,
   input logic [7:0] reg_wdata,
   input logic       priv_super,
   input logic [7:0] reg_rdata,
   input logic       acc_err,
   input logic       core_idle,
   input logic       core_clk_en,
   input logic       stop_ack,
   input logic       lock,
   input logic       wake,
   input logic       autos,
   input logic       stop,
   input logic       rx_fall
);
   assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[2:0] == 3'b000);

   assert_busy_keeps_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (core_clk_en && !core_idle && !autos) |=> core_clk_en);

   assert_ack_means_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ack |-> !core_clk_en);

   assert_gate_before_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_ack) |-> $past(!core_clk_en));

   assert_exit_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_ack && !stop) |=> (core_clk_en && !stop_ack));

   assert_self_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_ack && wake && rx_fall) |=> !stop);

   assert_arm_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[6] && !wake && rx_fall) |=> !wake);

   assert_nap_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_clk_en && !stop_ack && !stop) |-> (autos || $past(autos) || $past(stop)));

   assert_refused_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && lock && !priv_super) |=> (acc_err && lock && $stable(autos)));

   assert_err_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> $past(reg_wr && !priv_super));

   assert_refused_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && lock && !priv_super) |-> (reg_rdata == 8'h00));
endmodule

bind lpstop_ctrl lpstop_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_rd      (reg_rd),
   .reg_wdata   (reg_wdata),
   .priv_super  (priv_super),
   .reg_rdata   (reg_rdata),
   .acc_err     (acc_err),
   .core_idle   (core_idle),
   .core_clk_en (core_clk_en),
   .stop_ack    (stop_ack),
   .lock        (ctl.lock),
   .wake        (ctl.wake),
   .autos       (ctl.autos),
   .stop        (ctl.stop),
   .rx_fall     (rx_fall)
);

// File: tb/test_lpstop_ctrl.sv
`timescale 1ns/1ps
module test_lpstop_ctrl;
   localparam int unsigned S = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0, priv_super = 1'b1;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       acc_err, rx_pin = 1'b1, core_idle = 1'b1, task_pending = 1'b1;
   logic       core_clk_en, stop_ack;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   lpstop_ctrl #(.SYNC_STAGES(S), .WAKE_PRESENT(1'b1)) i_lpstop_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .priv_super(priv_super), .reg_rdata(reg_rdata),
      .acc_err(acc_err), .rx_pin(rx_pin), .core_idle(core_idle),
      .task_pending(task_pending), .core_clk_en(core_clk_en), .stop_ack(stop_ack)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d, input logic sup);
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = d; priv_super = sup;
      @(posedge clk); #1;
      reg_wr = 1'b0; priv_super = 1'b1;
   endtask

   task automatic rd(output logic [7:0] q, input logic sup);
      @(negedge clk);
      reg_rd = 1'b1; priv_super = sup;
      #1 q = reg_rdata;
      reg_rd = 1'b0; priv_super = 1'b1;
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] q;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      tick();

      // R1 reset state
      rd(q, 1'b1);
      chk("R1 readback", q, 8'h00);
      chk("R1 clk_en", {7'd0, core_clk_en}, 8'h01);
      chk("R1 ack", {7'd0, stop_ack}, 8'h00);

      // R2 sweep of write values with stop bit clear
      for (int v = 0; v < 256; v++) begin
         if (v[3]) continue;
         wr(8'(v), 1'b1);
         rd(q, 1'b1);
         chk("R2 readback", q, 8'(v) & 8'hE0);
      end
      wr(8'h00, 1'b1);

      // R3 busy core delays stop
      core_idle = 1'b0;
      wr(8'h08, 1'b1);
      repeat (5) tick();
      chk("R3 clk_en busy", {7'd0, core_clk_en}, 8'h01);
      chk("R3 ack busy", {7'd0, stop_ack}, 8'h00);
      @(negedge clk) core_idle = 1'b1;
      tick();
      chk("R4 clk_en gated", {7'd0, core_clk_en}, 8'h00);
      chk("R4 ack not yet", {7'd0, stop_ack}, 8'h00);
      tick();
      chk("R4 ack set", {7'd0, stop_ack}, 8'h01);
      rd(q, 1'b1);
      chk("R2 ack bit visible", q, 8'h18);

      // R5 exit by software
      wr(8'h00, 1'b1);
      chk("R5 still gated", {7'd0, core_clk_en}, 8'h00);
      tick();
      chk("R5 clk_en", {7'd0, core_clk_en}, 8'h01);
      chk("R5 ack", {7'd0, stop_ack}, 8'h00);

      // R6 self wake
      wr(8'h48, 1'b1);
      tick(); tick();
      chk("R6 stopped ack", {7'd0, stop_ack}, 8'h01);
      @(negedge clk) rx_pin = 1'b0;
      repeat (S + 1) tick();
      chk("R6 not yet awake", {7'd0, core_clk_en}, 8'h00);
      tick();
      chk("R6 clk_en awake", {7'd0, core_clk_en}, 8'h01);
      chk("R6 ack cleared", {7'd0, stop_ack}, 8'h00);
      rd(q, 1'b1);
      chk("R6 readback", q, 8'h40);
      @(negedge clk) rx_pin = 1'b1;
      repeat (S + 2) tick();

      // R7 edge ignored when not armed
      wr(8'h08, 1'b1);
      tick(); tick();
      @(negedge clk) rx_pin = 1'b0;
      repeat (8) tick();
      chk("R7 stays stopped", {6'd0, core_clk_en, stop_ack}, 8'h01);
      @(negedge clk) rx_pin = 1'b1;
      repeat (S + 2) tick();
      wr(8'h00, 1'b1);
      tick();

      // R8 arm refused when coinciding with edge
      @(negedge clk) rx_pin = 1'b0;
      repeat (S) @(posedge clk);
      wr(8'h48, 1'b1);
      rd(q, 1'b1);
      chk("R8 readback", q, 8'h00);
      repeat (3) tick();
      chk("R8 clock kept", {7'd0, core_clk_en}, 8'h01);
      @(negedge clk) rx_pin = 1'b1;
      repeat (S + 2) tick();
      wr(8'h40, 1'b1);
      rd(q, 1'b1);
      chk("R8 arm later ok", q, 8'h40);
      wr(8'h00, 1'b1);

      // R9 power-save
      task_pending = 1'b0;
      wr(8'h20, 1'b1);
      chk("R9 before nap", {7'd0, core_clk_en}, 8'h01);
      tick();
      chk("R9 nap gated", {6'd0, core_clk_en, stop_ack}, 8'h00);
      @(negedge clk) task_pending = 1'b1;
      tick();
      chk("R9 task wakes", {7'd0, core_clk_en}, 8'h01);
      @(negedge clk) task_pending = 1'b0;
      tick();
      chk("R9 regate", {7'd0, core_clk_en}, 8'h00);
      wr(8'h00, 1'b1);
      tick();
      chk("R9 mode off", {7'd0, core_clk_en}, 8'h01);
      repeat (3) tick();
      chk("R9 stays on", {7'd0, core_clk_en}, 8'h01);
      task_pending = 1'b1;

      // R10 lock
      wr(8'hA0, 1'b1);
      wr(8'h00, 1'b0);
      chk("R10 acc_err pulse", {7'd0, acc_err}, 8'h01);
      rd(q, 1'b1);
      chk("R10 unchanged", q, 8'hA0);
      tick();
      chk("R10 acc_err one cycle", {7'd0, acc_err}, 8'h00);
      rd(q, 1'b0);
      chk("R10 user read zero", q, 8'h00);

      // R11 unlocked user access
      wr(8'h00, 1'b1);
      wr(8'h20, 1'b0);
      chk("R11 no acc_err", {7'd0, acc_err}, 8'h00);
      rd(q, 1'b0);
      chk("R11 user read", q, 8'h20);
      wr(8'h00, 1'b0);
      rd(q, 1'b0);
      chk("R11 user clear", q, 8'h00);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule